// File: doc/BRIEF.md
# Self-Starting Serial Lane Deserializer

This block receives frames on one serial lane and rebuilds each data word. A frame is a start bit at level 1, then `WORD_W` data bits, then a stop bit at level 0. The receiver has no separate strobe. It arms itself when the line rises from 0 to 1, which is the step from the previous stop bit (or the idle-low line) to the new start bit. It then samples the data bits one per bit time and stops itself when a one-hot ring counter wraps. The finished word appears on a parallel output together with a one-cycle valid pulse.

The bit-rate clock is modelled as a clock enable, `bit_en`, on a synchronous clock. Every piece of state advances only on cycles where `bit_en` is high. A link with several lanes uses one instance per lane, so skew between lanes has no effect inside any one receiver.

The word output is a stream source with valid only and no ready. A serial line cannot be paused, so the receiver takes no back-pressure. A consumer must accept the word in the cycle `word_vld_o` is high. If it misses that cycle, it can still read `word_o`, which keeps the word until the next frame completes.

Top module: `ser_rx_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block idle. After it, `word_vld_o` is 0, `word_o` is all zeros, the remembered line level is 0 and the ring counter holds its home position.
- R2: While idle, a clock edge with `bit_en` high and `line_i` at 1 starts reception, provided the previously sampled line level was 0. That edge takes the start bit.
- R3: The next `WORD_W` enabled edges after the start bit each sample one data bit. The first data bit goes to `word_o[0]` and the last to `word_o[WORD_W-1]`.
- R4: `word_vld_o` rises after the enabled edge that samples the last data bit. It stays high for exactly one clock cycle per frame.
- R5: `word_o` changes only together with a `word_vld_o` pulse. Between frames it holds the last word received.
- R6: While reception is running, 0-to-1 transitions inside the data bits do not restart it. Exactly `WORD_W` bits are taken.
- R7: A frame whose start bit directly follows the previous frame's stop bit, with no idle time between them, is received correctly.
- R8: On cycles with `bit_en` low, nothing advances. Line activity during those cycles starts no frame and produces no `word_vld_o`.
- R9: A reset during a frame discards the partial word without any valid pulse. The next complete frame is then received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synchronous clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable; one serial bit is taken per enabled cycle |
| line_i | input | 1 | Serial lane input |
| word_o | output | WORD_W | Last received word, held between frames |
| word_vld_o | output | 1 | One-cycle pulse marking a new word on `word_o` |

## Verification
Frames are sent in several forms:
- Alternating-bit words such as 0x5555 and 0xAAAA put many 0-to-1 steps inside the data field. They separate a correct run flag from one that would restart on a data edge.
- All-ones, all-zeros and walking patterns test bit order and the handling of the last bit before the stop bit.
- Back-to-back frames, idle gaps and stretched bit periods (enable every second or third cycle) separate correct edge re-arming from logic that needs idle time or that runs on the clock instead of the enable.
- Line toggling with the enable held low, and a reset in mid-frame, show that gated cycles and aborted frames leave no trace in the next word.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

  localparam int unsigned RX_WORD_W = 16;

  // A start condition is a low level followed by a high level on the lane.
  function automatic logic rise_seen(input logic prev_lvl, input logic cur_lvl);
    return (!prev_lvl) && cur_lvl;
  endfunction

endpackage

// File: rtl/ser_rx_edge.sv
module ser_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_i,
  input  logic busy_i,
  output logic start_o
);
  logic prev_q;

  // Line level remembered on every enabled cycle; this re-arms on the stop bit.
  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (bit_en) prev_q <= line_i;
  end

  assign start_o = bit_en && !busy_i && ser_rx_pkg::rise_seen(prev_q, line_i);
endmodule

// File: rtl/ser_rx_ring.sv
module ser_rx_ring #(
  parameter int unsigned SLOTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic last_o
);
  localparam logic [SLOTS-1:0] HOME = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0] ring_q;

  generate
    if (SLOTS == 1) begin : g_single
      always_ff @(posedge clk) begin
        ring_q <= HOME;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)         ring_q <= HOME;
        else if (step_i) ring_q <= {ring_q[SLOTS-2:0], ring_q[SLOTS-1]};
      end
    end
  endgenerate

  // The top slot is reached on the final data bit; the next step wraps home.
  assign last_o = ring_q[SLOTS-1];
endmodule

// File: rtl/ser_rx_shift.sv
module ser_rx_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             load_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o,
  output logic             vld_o
);
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] sh_next;
  logic [WIDTH-1:0] word_q;
  logic             vld_q;

  // Bits arrive first-to-last and move toward bit 0.
  generate
    if (WIDTH == 1) begin : g_w1
      assign sh_next = bit_i;
    end else begin : g_wn
      assign sh_next = {bit_i, sh_q[WIDTH-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (shift_i) sh_q <= sh_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (load_i) word_q <= sh_next;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/ser_rx_top.sv
module ser_rx_top #(
  parameter int unsigned WORD_W = ser_rx_pkg::RX_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              line_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic run_q;
  logic start;
  logic last_slot;
  logic step;
  logic wrap;

  assign step = run_q && bit_en;
  assign wrap = step && last_slot;

  ser_rx_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .line_i  (line_i),
    .busy_i  (run_q),
    .start_o (start)
  );

  ser_rx_ring #(.SLOTS(WORD_W)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .last_o (last_slot)
  );

  ser_rx_shift #(.WIDTH(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (step),
    .load_i  (wrap),
    .bit_i   (line_i),
    .word_o  (word_o),
    .vld_o   (word_vld_o)
  );

  // Run flag: set by a start edge, cleared when the ring returns home.
  always_ff @(posedge clk) begin
    if (rst)        run_q <= 1'b0;
    else if (start) run_q <= 1'b1;
    else if (wrap)  run_q <= 1'b0;
  end
endmodule

// File: rtl/ser_rx_chk.sv
module ser_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              run_q,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);

  logic          armed;
  logic [CW-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // Independent count of enabled cycles spent running.
  always_ff @(posedge clk) begin
    if (rst || !run_q)   taken <= '0;
    else if (bit_en)     taken <= taken + 1'b1;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!word_vld_o && !run_q && word_o == '0));

  p_valid_after_run_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    word_vld_o |-> $past(run_q));

  p_run_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q && bit_en && taken == CW'(WORD_W - 1)) |=> !run_q);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (run_q && bit_en && taken < CW'(WORD_W - 1)) |=> run_q);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  p_word_hold_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    !word_vld_o |-> $stable(word_o));

  p_gated_quiet_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    !bit_en |=> (!word_vld_o && $stable(run_q)));
endmodule

bind ser_rx_top ser_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .run_q      (run_q),
  .word_o     (word_o),
  .word_vld_o (word_vld_o)
);

// File: tb/sim_ser_rx_top.sv
module sim_ser_rx_top;
  localparam int W       = 16;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 8;

  // Stimulus word, bit period in clocks, idle bits after the stop bit.
  localparam logic [W-1:0] VWORD [NVEC] = '{16'h5555, 16'hAAAA, 16'hFFFF, 16'h0000,
                                            16'h8001, 16'h1234, 16'hC3A5, 16'h7FFE};
  localparam int VPER [NVEC] = '{1, 1, 2, 3, 1, 2, 1, 3};
  localparam int VGAP [NVEC] = '{0, 0, 2, 0, 1, 0, 0, 4};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bit_en = 1'b0;
  logic         line_i = 1'b0;
  logic [W-1:0] word_o;
  logic         word_vld_o;

  int tests = 0;
  int fails = 0;
  int rx_cnt = 0;
  int dbl_cnt = 0;
  logic [W-1:0] last_rx = '0;
  logic vld_prev = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  ser_rx_top #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_i(line_i),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  // Monitor at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst && word_vld_o) begin
      rx_cnt  = rx_cnt + 1;
      last_rx = word_o;
      if (vld_prev) dbl_cnt = dbl_cnt + 1;
    end
    vld_prev = word_vld_o && !rst;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int per);
    @(negedge clk);
    line_i = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    for (int k = 1; k < per; k++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [W-1:0] w, input int per, input int gap);
    send_bit(1'b1, per);
    for (int i = 0; i < W; i++) send_bit(w[i], per);
    send_bit(1'b0, per);
    for (int g = 0; g < gap; g++) send_bit(1'b0, per);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(word_vld_o == 1'b0, "R1 valid after reset", W'(word_vld_o), '0);
    chk(word_o == '0, "R1 word after reset", word_o, '0);

    // Table walk: R2 R3 R6 R7 (patterns, stretched periods, back-to-back)
    for (int v = 0; v < NVEC; v++) begin
      base = rx_cnt;
      send_frame(VWORD[v], VPER[v], VGAP[v]);
      chk(rx_cnt == base + 1, "R2 R7 one word per frame", W'(rx_cnt - base), W'(1));
      chk(last_rx == VWORD[v], "R3 R6 word content", last_rx, VWORD[v]);
    end
    chk(dbl_cnt == 0, "R4 valid single cycle", W'(dbl_cnt), '0);

    // R5: idle line, word holds and no further valid
    base = rx_cnt;
    for (int k = 0; k < 40; k++) send_bit(1'b0, 1);
    chk(rx_cnt == base, "R5 no valid while idle", W'(rx_cnt - base), '0);
    chk(word_o == VWORD[NVEC-1], "R5 word held", word_o, VWORD[NVEC-1]);

    // R8: toggling with enable low does nothing
    base = rx_cnt;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      line_i = k[0];
    end
    @(negedge clk);
    line_i = 1'b0;
    chk(rx_cnt == base, "R8 gated toggles ignored", W'(rx_cnt - base), '0);
    send_frame(16'h0F0F, 1, 0);
    chk(last_rx == 16'h0F0F && rx_cnt == base + 1, "R8 next frame clean",
        last_rx, 16'h0F0F);

    // R9: reset in the middle of a frame
    base = rx_cnt;
    send_bit(1'b1, 1);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1);
    @(negedge clk);
    rst = 1'b1;
    line_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(word_o == '0 && !word_vld_o, "R9 reset mid-frame clears", word_o, '0);
    for (int i = 0; i < 12; i++) send_bit(1'b0, 1);
    chk(rx_cnt == base, "R9 no valid from aborted frame", W'(rx_cnt - base), '0);
    send_frame(16'hBEEF, 2, 1);
    chk(last_rx == 16'hBEEF && rx_cnt == base + 1, "R9 frame after abort", last_rx, 16'hBEEF);

    // R7: burst of three frames with no idle between
    base = rx_cnt;
    send_frame(16'h0001, 1, 0);
    send_frame(16'h8000, 1, 0);
    send_frame(16'hFFFF, 1, 0);
    chk(rx_cnt == base + 3, "R7 burst count", W'(rx_cnt - base), W'(3));
    chk(last_rx == 16'hFFFF, "R7 burst last word", last_rx, 16'hFFFF);
    chk(dbl_cnt == 0, "R4 valid single cycle final", W'(dbl_cnt), '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule